// File: doc/BRIEF.md
# Capture/Reload 16-Bit Timer

This block is a 16-bit up-counter controlled through a small byte-wide register window. It advances either on ticks of an internal prescaler, which divides the system clock by 4 or by 12, or on falling edges of an external count pin. The counter advances only while the run bit is set. When it steps past its all-ones value, it raises a sticky overflow flag and drives a one-cycle pulse output.

A 16-bit companion register serves one of two roles, chosen by a mode bit. In capture mode, a falling edge on the trigger pin latches the live count into the companion register, and an overflow wraps the count to zero. In reload mode, the companion register supplies the restart value. A reload happens on every overflow, and also on a trigger-pin falling edge. Any trigger event that is acted on also sets a sticky trigger flag. The interrupt request is high while either flag is set. Both external pins are resynchronized inside the block before their edges are detected.

Top module: `cr_timer16`

## Requirements
- R1: In timer mode (control bit 1 = 0), with the run bit set, the count advances once every 4 clock cycles when control bit 2 = 1 and once every 12 when it is 0. The first step comes that many cycles after the write that sets the run bit.
- R2: In counter mode (control bit 1 = 1), the count advances by exactly one for each falling edge on `cnt_pin`. The step takes effect on the third rising clock edge after the pin falls.
- R3: While the run bit (control bit 0) is 0, the count holds its value.
- R4: When the count steps past 0xFFFF, `ovf_flag` (control bit 7) is set and `ovf_pulse` is high for exactly one cycle.
- R5: With control bit 3 = 1 (capture mode), an overflow wraps the count to 0x0000. A trigger event copies the count into the companion register, taking the value before any increment in the same cycle.
- R6: With control bit 3 = 0 (reload mode), an overflow loads the count from the companion register.
- R7: In reload mode, a trigger event loads the count from the companion register without an overflow.
- R8: A trigger event is a falling edge on `trig_pin` while control bit 4 = 1. It sets `ext_flag` (control bit 6). While control bit 4 = 0, trigger-pin edges are ignored: no capture, no reload and no flag.
- R9: `irq` is high exactly while `ovf_flag` or `ext_flag` is set.
- R10: Both flags stay set until software writes 0 to their control bits. A hardware set in the same cycle wins over that clear.
- R11: A software write to either count byte takes priority over an increment or reload in the same cycle. The other byte keeps its old value.
- R12: Register map, reads combinational through `rd_addr`:
  - address 0: control.
  - addresses 1 and 2: count low and high byte.
  - addresses 3 and 4: companion register low and high byte.
  - Control bit 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| cnt_pin | input | 1 | External count input, asynchronous |
| trig_pin | input | 1 | External capture/reload trigger, asynchronous |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky trigger flag |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle pulse on overflow |

## Verification
A prescaler phase error shifts every count read by a whole step. It shows within one divide period of the run write, so sweeps over every wait length from zero expose it at once. A wrong wrap or reload value appears in the first count read after the overflow. The pulse counter and the overflow flag show a missed or doubled overflow within the same cycle. A capture or forced reload that ignores the trigger-enable bit, or takes the wrong value, shows in the companion or count bytes four cycles after the pin falls.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;
   // control register bit positions (software-visible layout)
   localparam int CTL_RUN    = 0;
   localparam int CTL_EXTCLK = 1;
   localparam int CTL_FAST   = 2;
   localparam int CTL_CAPT   = 3;
   localparam int CTL_TRIGEN = 4;
   localparam int CTL_EXTF   = 6;
   localparam int CTL_OVF    = 7;
   // register window: control first, then count bytes, then companion bytes
   localparam int ADDR_CTL      = 0;
   localparam int ADDR_CNT_BASE = 1;
endpackage

// File: rtl/cr_fall_detect.sv
module cr_fall_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cr_fall_detect: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   // reset to the idle-high level so no edge is seen out of reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/cr_prescaler.sv
module cr_prescaler #(
   parameter int SLOW_DIV = 12,
   parameter int FAST_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic fast,
   output logic tick
);
   localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
   localparam int PW   = $clog2(MAXD + 1);

   if (SLOW_DIV < 1 || FAST_DIV < 1) begin : g_bad_div
      $error("cr_prescaler: divide ratios must be at least 1");
   end

   logic [PW-1:0] ph_q;
   logic [PW-1:0] lim;

   assign lim  = fast ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
   assign tick = en && (ph_q >= lim);

   always_ff @(posedge clk) begin
      if (!rst_n || !en || tick) ph_q <= '0;
      else                       ph_q <= ph_q + 1'b1;
   end

   if (FAST_DIV > 1 && SLOW_DIV > 1) begin : g_gap_chk
      assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16 #(
   parameter int CNT_W       = 16,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int SLOW_DIV    = 12,
   parameter int FAST_DIV    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              cnt_pin,
   input  logic              trig_pin,
   output logic              ovf_flag,
   output logic              ext_flag,
   output logic              irq,
   output logic              ovf_pulse
);
   import cr_timer_pkg::*;

   localparam int NB       = CNT_W / 8;
   localparam int NREG     = 1 + 2 * NB;
   localparam int CMP_BASE = ADDR_CNT_BASE + NB;

   if (CNT_W % 8 != 0 || CNT_W < 8) begin : g_bad_width
      $error("cr_timer16: CNT_W must be a positive multiple of 8");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_addr
      $error("cr_timer16: ADDR_W too narrow for the register window");
   end

   // control state
   logic run_q, extclk_q, fast_q, capt_q, trigen_q, ovf_q, extf_q, pulse_q;
   logic [CNT_W-1:0] cnt_q, cmp_q, cnt_nxt, cmp_nxt;

   // edge sources
   logic cnt_fall, trig_fall, presc_tick;

   cr_fall_detect #(.STAGES(SYNC_STAGES)) u_cnt_edge (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(cnt_fall));

   cr_fall_detect #(.STAGES(SYNC_STAGES)) u_trig_edge (
      .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall));

   cr_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_presc (
      .clk(clk), .rst_n(rst_n), .en(run_q & ~extclk_q), .fast(fast_q),
      .tick(presc_tick));

   // events
   logic ctl_wr, inc, ovf_evt, trig_evt, reload_evt, capture_evt;
   logic cnt_hit, cmp_hit;

   assign ctl_wr      = wr_en && (wr_addr == ADDR_W'(ADDR_CTL));
   assign inc         = run_q & (extclk_q ? cnt_fall : presc_tick);
   assign ovf_evt     = inc & (&cnt_q);
   assign trig_evt    = trigen_q & trig_fall;
   assign reload_evt  = ~capt_q & (ovf_evt | trig_evt);
   assign capture_evt = capt_q & trig_evt;

   // count and companion next state; software byte writes override lanes
   always_comb begin
      cnt_hit = 1'b0;
      cmp_hit = 1'b0;
      for (int i = 0; i < NB; i++) begin
         if (wr_en && wr_addr == ADDR_W'(ADDR_CNT_BASE + i)) cnt_hit = 1'b1;
         if (wr_en && wr_addr == ADDR_W'(CMP_BASE + i))      cmp_hit = 1'b1;
      end

      if (cnt_hit)         cnt_nxt = cnt_q;
      else if (reload_evt) cnt_nxt = cmp_q;
      else if (inc)        cnt_nxt = cnt_q + 1'b1;
      else                 cnt_nxt = cnt_q;

      cmp_nxt = capture_evt ? cnt_q : cmp_q;

      for (int i = 0; i < NB; i++) begin
         if (wr_en && wr_addr == ADDR_W'(ADDR_CNT_BASE + i)) cnt_nxt[i*8 +: 8] = wr_data;
         if (wr_en && wr_addr == ADDR_W'(CMP_BASE + i))      cmp_nxt[i*8 +: 8] = wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         extclk_q <= 1'b0;
         fast_q   <= 1'b0;
         capt_q   <= 1'b0;
         trigen_q <= 1'b0;
         ovf_q    <= 1'b0;
         extf_q   <= 1'b0;
         pulse_q  <= 1'b0;
         cnt_q    <= '0;
         cmp_q    <= '0;
      end else begin
         if (ctl_wr) begin
            run_q    <= wr_data[CTL_RUN];
            extclk_q <= wr_data[CTL_EXTCLK];
            fast_q   <= wr_data[CTL_FAST];
            capt_q   <= wr_data[CTL_CAPT];
            trigen_q <= wr_data[CTL_TRIGEN];
         end
         // hardware set wins over a software clear in the same cycle
         ovf_q   <= ovf_evt  | (ctl_wr ? wr_data[CTL_OVF]  : ovf_q);
         extf_q  <= trig_evt | (ctl_wr ? wr_data[CTL_EXTF] : extf_q);
         pulse_q <= ovf_evt;
         cnt_q   <= cnt_nxt;
         cmp_q   <= cmp_nxt;
      end
   end

   // read window
   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(ADDR_CTL)) begin
         rd_data[CTL_RUN]    = run_q;
         rd_data[CTL_EXTCLK] = extclk_q;
         rd_data[CTL_FAST]   = fast_q;
         rd_data[CTL_CAPT]   = capt_q;
         rd_data[CTL_TRIGEN] = trigen_q;
         rd_data[CTL_EXTF]   = extf_q;
         rd_data[CTL_OVF]    = ovf_q;
      end
      for (int i = 0; i < NB; i++) begin
         if (rd_addr == ADDR_W'(ADDR_CNT_BASE + i)) rd_data = cnt_q[i*8 +: 8];
         if (rd_addr == ADDR_W'(CMP_BASE + i))      rd_data = cmp_q[i*8 +: 8];
      end
   end

   assign ovf_flag  = ovf_q;
   assign ext_flag  = extf_q;
   assign irq       = ovf_q | extf_q;
   assign ovf_pulse = pulse_q;

   // checks on the sequential behaviour
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !cnt_hit && !reload_evt) |=> $stable(cnt_q));

   assert_pulse_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> ovf_flag);

   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (capt_q && ovf_evt && !cnt_hit) |=> (cnt_q == '0));

   assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_evt && !cmp_hit) |=> (cmp_q == $past(cnt_q)));

   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!capt_q && ovf_evt && !cnt_hit) |=> (cnt_q == $past(cmp_q)));

   assert_trig_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_evt |=> ext_flag);

   assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> (ovf_flag && ovf_pulse));
endmodule

// File: tb/tb_cr_timer16.sv
module tb_cr_timer16;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       cnt_pin = 1'b1;
   logic       trig_pin = 1'b1;
   logic       ovf_flag, ext_flag, irq, ovf_pulse;

   int checks = 0;
   int errors = 0;
   int pulses_total = 0;
   int dbl_pulses = 0;
   logic prev_pulse = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cr_timer16 dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .cnt_pin(cnt_pin), .trig_pin(trig_pin), .ovf_flag(ovf_flag),
      .ext_flag(ext_flag), .irq(irq), .ovf_pulse(ovf_pulse));

   // pulse monitor, sampled in the low phase
   always @(negedge clk) begin
      if (ovf_pulse) pulses_total++;
      if (ovf_pulse && prev_pulse) dbl_pulses++;
      prev_pulse = ovf_pulse;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // entered and left at a falling edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic rd16(input logic [2:0] base, output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(base, lo); rd(base + 3'd1, hi);
      v = {hi, lo};
   endtask

   task automatic wr16(input logic [2:0] base, input logic [15:0] v);
      wr(base, v[7:0]); wr(base + 3'd1, v[15:8]);
   endtask

   // arithmetic model of k increments with restart value rl after 0xFFFF
   task automatic model(input logic [15:0] start, input logic [15:0] rl,
                        input int k, output logic [15:0] v, output int wraps);
      v = start; wraps = 0;
      for (int i = 0; i < k; i++) begin
         if (v == 16'hFFFF) begin v = rl; wraps++; end
         else v = v + 16'd1;
      end
   endtask

   // timer-mode sweep over every wait length up to mmax
   task automatic sweep(input string req, input bit capt, input bit fast,
                        input int mmax, input logic [15:0] start, input logic [15:0] rl);
      int div;
      logic [15:0] v, exp_v;
      int wraps, base;
      div = fast ? 4 : 12;
      for (int m = 0; m <= mmax; m++) begin
         wr(3'd0, 8'h00);
         wr16(3'd3, rl);
         wr16(3'd1, start);
         base = pulses_total;
         wr(3'd0, {4'b0, capt, fast, 1'b0, 1'b1});
         repeat (m) @(negedge clk);
         rd16(3'd1, v);
         model(start, capt ? 16'h0000 : rl, m / div, exp_v, wraps);
         check(req, int'(v), int'(exp_v));
         if (wraps > 0) begin
            check("R4 pulse count", pulses_total - base, wraps);
            check("R4 flag", int'(ovf_flag), 1);
         end
      end
      wr(3'd0, 8'h00);
   endtask

   task automatic pin_fall_cnt;
      cnt_pin = 1'b0; repeat (3) @(negedge clk);
      cnt_pin = 1'b1; repeat (3) @(negedge clk);
   endtask

   task automatic pin_fall_trig;
      trig_pin = 1'b0; repeat (4) @(negedge clk);
      trig_pin = 1'b1; repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] v;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R12 map)
      rd(3'd0, b);  check("R12 reset ctrl", int'(b), 0);
      rd16(3'd1, v); check("R12 reset count", int'(v), 0);
      rd16(3'd3, v); check("R12 reset companion", int'(v), 0);
      check("R9 reset irq", int'(irq), 0);
      check("R4 reset pulse", int'(ovf_pulse), 0);

      // R12 register read-back, bit 5 reads 0
      wr(3'd0, 8'h3A); rd(3'd0, b); check("R12 ctrl readback", int'(b), 8'h1A);
      wr16(3'd3, 16'hA55A); rd16(3'd3, v); check("R12 companion readback", int'(v), 16'hA55A);
      wr(3'd0, 8'h00);

      // R1 timer mode, both divide ratios
      sweep("R1 div4", 1'b0, 1'b1, 40, 16'h0000, 16'h0000);
      sweep("R1 div12", 1'b0, 1'b0, 60, 16'h0100, 16'h0000);

      // R6 reload on overflow, R5 wrap in capture mode (with R4 pulses)
      sweep("R6 reload", 1'b0, 1'b1, 80, 16'hFFFC, 16'hFFF8);
      sweep("R5 wrap", 1'b1, 1'b1, 60, 16'hFFFC, 16'h1234);
      check("R4 single-cycle pulse", dbl_pulses, 0);

      // R3 run bit clear holds the count
      wr16(3'd1, 16'h4321);
      wr(3'd0, 8'h04);
      repeat (30) @(negedge clk);
      rd16(3'd1, v); check("R3 hold", int'(v), 16'h4321);

      // R2 counter mode, n falls each
      for (int n = 0; n <= 10; n++) begin
         wr(3'd0, 8'h00);
         wr16(3'd1, 16'h00F8);
         wr(3'd0, 8'h03);
         for (int j = 0; j < n; j++) pin_fall_cnt();
         repeat (6) @(negedge clk);
         rd16(3'd1, v); check("R2 counter", int'(v), 16'h00F8 + n);
      end
      wr(3'd0, 8'h00);

      // R11 byte write collides with an increment (carry must not reach high byte)
      wr16(3'd1, 16'h00FF);
      wr(3'd0, 8'h05);
      repeat (3) @(negedge clk);
      wr(3'd1, 8'h55);
      wr(3'd0, 8'h00);
      rd16(3'd1, v); check("R11 write priority", int'(v), 16'h0055);

      // R8 trigger ignored when disabled, capture mode
      wr16(3'd3, 16'hAAAA);
      wr16(3'd1, 16'h1234);
      wr(3'd0, 8'h08);
      pin_fall_trig();
      rd16(3'd3, v); check("R8 disabled no capture", int'(v), 16'hAAAA);
      check("R8 disabled no flag", int'(ext_flag), 0);
      check("R9 irq low", int'(irq), 0);

      // R5 capture with trigger enabled
      wr(3'd0, 8'h18);
      pin_fall_trig();
      rd16(3'd3, v); check("R5 capture", int'(v), 16'h1234);
      check("R8 flag set", int'(ext_flag), 1);
      check("R9 irq from trigger flag", int'(irq), 1);
      repeat (20) @(negedge clk);
      check("R10 sticky", int'(ext_flag), 1);
      wr(3'd0, 8'h00);
      check("R10 clear", int'(ext_flag), 0);
      check("R9 irq cleared", int'(irq), 0);

      // R7 forced reload, and ignored when disabled
      wr16(3'd3, 16'hBEEF);
      wr16(3'd1, 16'h0102);
      wr(3'd0, 8'h00);
      pin_fall_trig();
      rd16(3'd1, v); check("R8 disabled no reload", int'(v), 16'h0102);
      wr(3'd0, 8'h10);
      pin_fall_trig();
      rd16(3'd1, v); check("R7 forced reload", int'(v), 16'hBEEF);
      check("R8 flag on reload", int'(ext_flag), 1);
      wr(3'd0, 8'h00);

      // R9/R10 overflow flag alone drives irq and stays until cleared
      wr16(3'd1, 16'hFFFF);
      wr(3'd0, 8'h05);
      repeat (6) @(negedge clk);
      wr(3'd0, 8'h80);
      check("R10 ovf sticky", int'(ovf_flag), 1);
      check("R9 irq from ovf", int'(irq), 1);
      wr(3'd0, 8'h00);
      check("R10 ovf clear", int'(ovf_flag), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule